// File: doc/BRIEF.md
# Counter-Tagged Multi-Stream Frame Aligner

This block takes in several narrow sample streams that all arrive in one clock domain. On each valid beat a stream delivers a few data bits and one bit of a shared time counter. The counter is sent serially, most significant bit first, across a frame of beats, and a start marker flags the first beat of each frame. Two antenna channels share one stream, and the block treats them as opaque data. For each stream the block rebuilds the frame's counter and data word and stores the completed frame in a per-stream FIFO.

An aligner looks at the head frame of every FIFO. When all the heads carry the same counter value, it pops one frame from each FIFO and presents them together as one word-aligned tuple. When the heads differ, it discards the head of every stream that is behind the newest one. Streams that started late or lost frames therefore pull back into step without outside help. A lock output reports a sustained run of matched tuples.

Each stream has a sticky overflow flag. The flag is set when a finished frame finds its FIFO full, and it stays set until an explicit clear input is pulsed.

Top module: `ctr_stream_aligner`

## Requirements
- R1: A frame starts on a valid beat with `in_sof` high and ends after 16 valid beats. Cycles with `in_vld` low may fall between beats and do not count. The counter bit of the first beat is bit 15 of the recovered counter. The data nibble of the first beat lands in bits 63:60 of the 64-bit frame word, and each later nibble lands in the next lower nibble.
- R2: A valid beat with `in_sof` high during an unfinished frame drops the partial frame and starts a new one. A valid beat with `in_sof` low while no frame is open is ignored.
- R3: A tuple is released only when every FIFO holds at least one frame and all head counters are equal. That clock edge pops one frame from each FIFO. `out_vld` is high for one cycle after that edge. In that cycle `out_cnt` holds the common counter and `out_data[i*64 +: 64]` holds the data of stream i. A frame becomes a candidate for release at the second clock edge after its last beat.
- R4: When every FIFO holds a frame but the head counters differ, no tuple is released. At that edge, every stream whose head counter differs from the newest head is popped. "Newer" is judged by the 16-bit difference read as a signed number, so counter wrap-around is handled.
- R5: `lock` rises at the same edge as the fourth consecutive released tuple. Any edge that discards heads clears `lock` and restarts the count. Cycles with an empty FIFO leave `lock` unchanged.
- R6: Each FIFO holds 64 frames. A frame completed while its FIFO is full is discarded and sets `ovf_flag[i]`. Fullness is judged before any pop made at the same edge.
- R7: `ovf_flag` bits stay set until `ovf_clr` is high at a clock edge. If an overflow and a clear fall on the same edge, the flag ends up set.
- R8: While `rst` is high at a clock edge, `out_vld`, `lock` and `ovf_flag` are cleared, the FIFOs are emptied and every partial frame is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all streams |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | N_STRM | Beat valid, one bit per stream |
| in_sof | input | N_STRM | Frame-start marker, one bit per stream |
| in_dat | input | N_STRM*DATA_W | Data nibble per stream, stream i at [i*DATA_W +: DATA_W] |
| in_cbit | input | N_STRM | Serial counter bit per stream |
| ovf_clr | input | 1 | Clears every overflow flag |
| out_vld | output | 1 | Aligned tuple valid |
| out_cnt | output | CNT_W | Common counter of the tuple |
| out_data | output | N_STRM*CNT_W*DATA_W | Frame data of every stream |
| lock | output | 1 | Sustained alignment indicator |
| ovf_flag | output | N_STRM | Sticky per-stream overflow flags |

## Verification
Two pairs of events can land on the same clock edge. The first pair is an overflow and a flag clear. The bench fills two FIFOs by starving the third stream, then pulses `ovf_clr` every seven cycles while frames keep arriving every sixteen. Over about ten frames this makes an overflow edge meet a clear edge, and the reference model requires the flag to stay set at that edge. The second pair is a pop and a write into a full FIFO. While stale frames are discarded, the model judges fullness before the pop, and it compares the outputs and flags on every clock.

// File: rtl/aln_pkg.sv
package aln_pkg;

  // Deserializer frame state
  typedef enum logic {
    DS_IDLE = 1'b0,
    DS_BUSY = 1'b1
  } ds_state_e;

  // Default geometry shared by the modules
  localparam int DEF_N_STRM     = 3;
  localparam int DEF_DATA_W     = 4;
  localparam int DEF_CNT_W      = 16;
  localparam int DEF_FIFO_DEPTH = 64;
  localparam int DEF_LOCK_N     = 4;

endpackage

// File: rtl/strm_deser.sv
module strm_deser
  import aln_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int CNT_W  = DEF_CNT_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     vld,
  input  logic                     sof,
  input  logic [DATA_W-1:0]        dat,
  input  logic                     cbit,
  output logic                     push,
  output logic [CNT_W-1:0]         frame_cnt,
  output logic [CNT_W*DATA_W-1:0]  frame_dat
);

  localparam int BEATS   = CNT_W;
  localparam int FRAME_W = BEATS * DATA_W;
  localparam int IDX_W   = $clog2(BEATS) + 1;

  ds_state_e            st_q;
  logic [IDX_W-1:0]     idx_q;
  logic [CNT_W-1:0]     csr_q;
  logic [FRAME_W-1:0]   dsr_q;
  logic [CNT_W-1:0]     c_nx;
  logic [FRAME_W-1:0]   d_nx;

  assign c_nx = {csr_q[CNT_W-2:0], cbit};
  assign d_nx = {dsr_q[FRAME_W-DATA_W-1:0], dat};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= DS_IDLE;
      idx_q     <= '0;
      csr_q     <= '0;
      dsr_q     <= '0;
      push      <= 1'b0;
      frame_cnt <= '0;
      frame_dat <= '0;
    end else begin
      push <= 1'b0;
      if (vld) begin
        if (sof) begin
          st_q  <= DS_BUSY;
          idx_q <= IDX_W'(1);
          csr_q <= {{(CNT_W-1){1'b0}}, cbit};
          dsr_q <= {{(FRAME_W-DATA_W){1'b0}}, dat};
        end else if (st_q == DS_BUSY) begin
          csr_q <= c_nx;
          dsr_q <= d_nx;
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_W'(BEATS-1)) begin
            push      <= 1'b1;
            frame_cnt <= c_nx;
            frame_dat <= d_nx;
            st_q      <= DS_IDLE;
          end
        end
      end
    end
  end

  // R1: a frame needs many beats, so completions never come back to back
  p_push_spacing_r1: assert property (@(posedge clk) disable iff (rst)
    push |=> !push);

  // R1: a completion is always caused by a valid beat one edge earlier
  p_push_from_beat_r1: assert property (@(posedge clk) disable iff (rst)
    push |-> $past(vld));

endmodule

// File: rtl/frame_fifo.sv
module frame_fifo
  import aln_pkg::*;
#(
  parameter int WIDTH = DEF_CNT_W * (DEF_DATA_W + 1),
  parameter int DEPTH = DEF_FIFO_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full,
  output logic             ovf_evt
);

  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wr_ptr_q;
  logic [AW:0]      rd_ptr_q;
  logic             wr_ok;

  assign empty   = (wr_ptr_q == rd_ptr_q);
  assign full    = (wr_ptr_q[AW] != rd_ptr_q[AW]) &&
                   (wr_ptr_q[AW-1:0] == rd_ptr_q[AW-1:0]);
  assign wr_ok   = wr_en && !full;
  assign ovf_evt = wr_en && full;
  assign rd_data = mem[rd_ptr_q[AW-1:0]];

  // Storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr_q[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_ok)          wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_en && !empty) rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  // R6: a write into a full FIFO with no pop leaves it full
  p_full_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en) |=> full);

  // R3: the aligner never pops an empty FIFO
  p_no_pop_empty_r3: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);

endmodule

// File: rtl/head_align.sv
module head_align
  import aln_pkg::*;
#(
  parameter int N_STRM  = DEF_N_STRM,
  parameter int CNT_W   = DEF_CNT_W,
  parameter int FRAME_W = DEF_CNT_W * DEF_DATA_W,
  parameter int LOCK_N  = DEF_LOCK_N
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_STRM-1:0]           head_ne,
  input  logic [N_STRM*CNT_W-1:0]     head_cnt,
  input  logic [N_STRM*FRAME_W-1:0]   head_dat,
  output logic [N_STRM-1:0]           pop,
  output logic                        out_vld,
  output logic [CNT_W-1:0]            out_cnt,
  output logic [N_STRM*FRAME_W-1:0]   out_dat,
  output logic                        lock
);

  localparam int RUN_W = $clog2(LOCK_N + 1);

  logic [CNT_W-1:0] newest;
  logic [CNT_W-1:0] diff;
  logic             all_ne;
  logic             all_eq;
  logic             emit;
  logic             drop;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_nx;

  // Newest head by modular comparison, and equality of all heads
  always_comb begin
    newest = head_cnt[0 +: CNT_W];
    all_eq = 1'b1;
    diff   = '0;
    for (int i = 1; i < N_STRM; i++) begin
      diff = head_cnt[i*CNT_W +: CNT_W] - newest;
      if (!diff[CNT_W-1] && (diff != '0)) newest = head_cnt[i*CNT_W +: CNT_W];
      if (head_cnt[i*CNT_W +: CNT_W] != head_cnt[0 +: CNT_W]) all_eq = 1'b0;
    end
  end

  assign all_ne = &head_ne;
  assign emit   = all_ne && all_eq;
  assign drop   = all_ne && !all_eq;

  for (genvar g = 0; g < N_STRM; g++) begin : g_pop
    assign pop[g] = emit || (drop && (head_cnt[g*CNT_W +: CNT_W] != newest));
  end

  assign run_nx = (run_q == RUN_W'(LOCK_N)) ? run_q : run_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_cnt <= '0;
      out_dat <= '0;
      run_q   <= '0;
      lock    <= 1'b0;
    end else begin
      out_vld <= emit;
      if (emit) begin
        out_cnt <= head_cnt[0 +: CNT_W];
        out_dat <= head_dat;
        run_q   <= run_nx;
        lock    <= (run_nx == RUN_W'(LOCK_N));
      end else if (drop) begin
        run_q <= '0;
        lock  <= 1'b0;
      end
    end
  end

  // R3: a tuple only follows a cycle in which every FIFO held a frame
  p_emit_needs_data_r3: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(all_ne));

  // R5: discarding heads removes lock at the next edge
  p_drop_unlocks_r5: assert property (@(posedge clk) disable iff (rst)
    drop |=> !lock);

  // R5: lock can only rise together with a released tuple
  p_lock_with_emit_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> out_vld);

endmodule

// File: rtl/ctr_stream_aligner.sv
module ctr_stream_aligner
  import aln_pkg::*;
#(
  parameter int N_STRM     = DEF_N_STRM,
  parameter int DATA_W     = DEF_DATA_W,
  parameter int CNT_W      = DEF_CNT_W,
  parameter int FIFO_DEPTH = DEF_FIFO_DEPTH,
  parameter int LOCK_N     = DEF_LOCK_N
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [N_STRM-1:0]                in_vld,
  input  logic [N_STRM-1:0]                in_sof,
  input  logic [N_STRM*DATA_W-1:0]         in_dat,
  input  logic [N_STRM-1:0]                in_cbit,
  input  logic                             ovf_clr,
  output logic                             out_vld,
  output logic [CNT_W-1:0]                 out_cnt,
  output logic [N_STRM*CNT_W*DATA_W-1:0]   out_data,
  output logic                             lock,
  output logic [N_STRM-1:0]                ovf_flag
);

  localparam int FRAME_W = CNT_W * DATA_W;
  localparam int WORD_W  = FRAME_W + CNT_W;

  logic [N_STRM-1:0]          push;
  logic [N_STRM-1:0]          pop;
  logic [N_STRM-1:0]          empty;
  logic [N_STRM-1:0]          full;
  logic [N_STRM-1:0]          ovf_evt;
  logic [N_STRM*CNT_W-1:0]    head_cnt;
  logic [N_STRM*FRAME_W-1:0]  head_dat;

  for (genvar s = 0; s < N_STRM; s++) begin : g_strm
    logic [CNT_W-1:0]   fr_cnt;
    logic [FRAME_W-1:0] fr_dat;
    logic [WORD_W-1:0]  head_word;

    strm_deser #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
    ) deser_i (
      .clk       (clk),
      .rst       (rst),
      .vld       (in_vld[s]),
      .sof       (in_sof[s]),
      .dat       (in_dat[s*DATA_W +: DATA_W]),
      .cbit      (in_cbit[s]),
      .push      (push[s]),
      .frame_cnt (fr_cnt),
      .frame_dat (fr_dat)
    );

    frame_fifo #(
      .WIDTH (WORD_W),
      .DEPTH (FIFO_DEPTH)
    ) fifo_i (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (push[s]),
      .wr_data ({fr_cnt, fr_dat}),
      .rd_en   (pop[s]),
      .rd_data (head_word),
      .empty   (empty[s]),
      .full    (full[s]),
      .ovf_evt (ovf_evt[s])
    );

    assign head_cnt[s*CNT_W +: CNT_W]     = head_word[FRAME_W +: CNT_W];
    assign head_dat[s*FRAME_W +: FRAME_W] = head_word[FRAME_W-1:0];

    // Sticky overflow flag, a new overflow wins over a clear
    always_ff @(posedge clk) begin
      if (rst)               ovf_flag[s] <= 1'b0;
      else if (ovf_evt[s])   ovf_flag[s] <= 1'b1;
      else if (ovf_clr)      ovf_flag[s] <= 1'b0;
    end

    // R7: without a clear the flag never falls
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      (ovf_flag[s] && !ovf_clr) |=> ovf_flag[s]);

    // R6: a frame arriving at a full FIFO raises the flag
    p_ovf_on_full_r6: assert property (@(posedge clk) disable iff (rst)
      (push[s] && full[s]) |=> ovf_flag[s]);
  end

  head_align #(
    .N_STRM  (N_STRM),
    .CNT_W   (CNT_W),
    .FRAME_W (FRAME_W),
    .LOCK_N  (LOCK_N)
  ) align_i (
    .clk      (clk),
    .rst      (rst),
    .head_ne  (~empty),
    .head_cnt (head_cnt),
    .head_dat (head_dat),
    .pop      (pop),
    .out_vld  (out_vld),
    .out_cnt  (out_cnt),
    .out_dat  (out_data),
    .lock     (lock)
  );

endmodule

// File: tb/ctr_stream_aligner_tb_top.sv
module ctr_stream_aligner_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N     = 3;
  localparam int DW    = 4;
  localparam int CW    = 16;
  localparam int FW    = 64;
  localparam int WW    = 80;
  localparam int DEPTH = 64;
  localparam int LOCKN = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    in_vld = '0;
  logic [N-1:0]    in_sof = '0;
  logic [N*DW-1:0] in_dat = '0;
  logic [N-1:0]    in_cbit = '0;
  logic            ovf_clr = 1'b0;
  logic            out_vld;
  logic [CW-1:0]   out_cnt;
  logic [N*FW-1:0] out_data;
  logic            lock;
  logic [N-1:0]    ovf_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctr_stream_aligner dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_sof(in_sof), .in_dat(in_dat),
    .in_cbit(in_cbit), .ovf_clr(ovf_clr), .out_vld(out_vld), .out_cnt(out_cnt),
    .out_data(out_data), .lock(lock), .ovf_flag(ovf_flag)
  );

  typedef struct packed {
    logic       v;
    logic       s;
    logic [3:0] d;
    logic       c;
  } beat_t;

  beat_t bq[N][$];

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    clr_period = 0;
  int    dut_emits = 0;
  string ptag = "R8";
  logic  started = 1'b0;

  // Behavioural reference state
  logic [WW-1:0]   mq[N][$];
  logic            m_fr[N];
  int              m_idx[N];
  logic [CW-1:0]   m_c[N];
  logic [FW-1:0]   m_d[N];
  logic            m_pend[N];
  logic [WW-1:0]   m_pw[N];
  int              m_run;
  logic            e_vld;
  logic            e_lock;
  logic [CW-1:0]   e_cnt;
  logic [N*FW-1:0] e_dat;
  logic [N-1:0]    e_ovf;

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < N; s++) begin
      mq[s].delete();
      m_fr[s] = 1'b0; m_idx[s] = 0; m_c[s] = '0; m_d[s] = '0;
      m_pend[s] = 1'b0; m_pw[s] = '0;
    end
    m_run = 0; e_vld = 1'b0; e_lock = 1'b0; e_cnt = '0; e_dat = '0; e_ovf = '0;
  endtask

  task automatic model_step();
    bit full_pre[N];
    bit all_ne;
    bit all_eq;
    logic [CW-1:0] h[N];
    logic [CW-1:0] newest;
    for (int s = 0; s < N; s++) full_pre[s] = (mq[s].size() >= DEPTH);
    all_ne = 1'b1;
    for (int s = 0; s < N; s++) if (mq[s].size() == 0) all_ne = 1'b0;
    e_vld = 1'b0;
    if (all_ne) begin
      for (int s = 0; s < N; s++) h[s] = mq[s][0][WW-1:FW];
      newest = h[0];
      all_eq = 1'b1;
      for (int s = 1; s < N; s++) begin
        logic signed [CW-1:0] dd;
        dd = h[s] - newest;
        if (dd > 0) newest = h[s];
        if (h[s] != h[0]) all_eq = 1'b0;
      end
      if (all_eq) begin
        e_vld = 1'b1;
        e_cnt = h[0];
        for (int s = 0; s < N; s++) begin
          e_dat[s*FW +: FW] = mq[s][0][FW-1:0];
          void'(mq[s].pop_front());
        end
        if (m_run < LOCKN) m_run++;
        e_lock = (m_run >= LOCKN);
      end else begin
        for (int s = 0; s < N; s++) if (h[s] != newest) void'(mq[s].pop_front());
        m_run = 0;
        e_lock = 1'b0;
      end
    end
    for (int s = 0; s < N; s++) begin
      if (ovf_clr) e_ovf[s] = 1'b0;
      if (m_pend[s]) begin
        if (full_pre[s]) e_ovf[s] = 1'b1;
        else mq[s].push_back(m_pw[s]);
      end
      m_pend[s] = 1'b0;
    end
    for (int s = 0; s < N; s++) begin
      if (in_vld[s]) begin
        if (in_sof[s]) begin
          m_fr[s] = 1'b1; m_idx[s] = 1;
          m_c[s] = CW'(in_cbit[s]);
          m_d[s] = FW'(in_dat[s*DW +: DW]);
        end else if (m_fr[s]) begin
          m_c[s] = {m_c[s][CW-2:0], in_cbit[s]};
          m_d[s] = {m_d[s][FW-DW-1:0], in_dat[s*DW +: DW]};
          m_idx[s]++;
          if (m_idx[s] == CW) begin
            m_pend[s] = 1'b1;
            m_pw[s] = {m_c[s], m_d[s]};
            m_fr[s] = 1'b0;
          end
        end
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) model_reset();
    else model_step();
  end

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !rst) begin
      chk(ptag, 256'(out_vld), 256'(e_vld), "out_vld");
      if (e_vld) begin
        chk(ptag, 256'(out_cnt), 256'(e_cnt), "out_cnt");
        chk(ptag, 256'(out_data), 256'(e_dat), "out_data");
      end
      chk("R5", 256'(lock), 256'(e_lock), "lock");
      chk("R7", 256'(ovf_flag), 256'(e_ovf), "ovf_flag");
      if (out_vld) dut_emits++;
    end
  end

  function automatic logic [FW-1:0] fdat(int s, logic [CW-1:0] c);
    return {c ^ 16'h5A3C, 16'(s * 4369), ~c, c + 16'(s)};
  endfunction

  task automatic add_frame(int s, logic [CW-1:0] c, int gap);
    logic [FW-1:0] d;
    d = fdat(s, c);
    for (int b = 0; b < CW; b++)
      bq[s].push_back('{v: 1'b1, s: (b == 0), d: d[FW-1-4*b -: 4], c: c[CW-1-b]});
    for (int g = 0; g < gap; g++) bq[s].push_back('0);
  endtask

  task automatic add_frame_gappy(int s, logic [CW-1:0] c);
    logic [FW-1:0] d;
    d = fdat(s, c);
    for (int b = 0; b < CW; b++) begin
      bq[s].push_back('{v: 1'b1, s: (b == 0), d: d[FW-1-4*b -: 4], c: c[CW-1-b]});
      bq[s].push_back('0);
    end
  endtask

  task automatic add_partial(int s, int nb);
    for (int b = 0; b < nb; b++)
      bq[s].push_back('{v: 1'b1, s: (b == 0), d: 4'hE, c: 1'b1});
  endtask

  task automatic add_stray(int s, int nb);
    for (int b = 0; b < nb; b++) bq[s].push_back('{v: 1'b1, s: 1'b0, d: 4'hF, c: 1'b1});
  endtask

  task automatic add_idle(int s, int nb);
    for (int b = 0; b < nb; b++) bq[s].push_back('0);
  endtask

  task automatic play(int tail);
    int left;
    bit any;
    left = tail;
    while (1) begin
      any = 1'b0;
      @(negedge clk);
      for (int s = 0; s < N; s++) begin
        beat_t b;
        b = '0;
        if (bq[s].size() > 0) begin
          b = bq[s].pop_front();
          any = 1'b1;
        end
        in_vld[s] = b.v; in_sof[s] = b.s; in_cbit[s] = b.c;
        in_dat[s*DW +: DW] = b.d;
      end
      ovf_clr = (clr_period > 0) && (cyc % clr_period == 0);
      if (!any) begin
        if (left == 0) break;
        left--;
      end
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    // R8: reset state
    chk("R8", 256'(out_vld), 256'(0), "out_vld in reset");
    chk("R8", 256'(lock), 256'(0), "lock in reset");
    chk("R8", 256'(ovf_flag), 256'(0), "ovf_flag in reset");
    rst = 1'b0;
    started = 1'b1;

    // R3: aligned streams, eight matching frames
    ptag = "R3"; dut_emits = 0;
    for (int s = 0; s < N; s++)
      for (int k = 0; k < 8; k++) add_frame(s, CW'(100 + k), 0);
    play(8);
    chk("R3", 256'(dut_emits), 256'(8), "tuples aligned run");
    chk("R5", 256'(lock), 256'(1), "lock after eight tuples");

    // R4: stream 1 carries two older frames that must be discarded
    ptag = "R4"; dut_emits = 0;
    add_frame(1, CW'(198), 0); add_frame(1, CW'(199), 0);
    for (int s = 0; s < N; s++)
      for (int k = 0; k < 6; k++) add_frame(s, CW'(200 + k), 0);
    play(8);
    chk("R4", 256'(dut_emits), 256'(6), "tuples after skew");
    chk("R5", 256'(lock), 256'(1), "relock after skew");

    // R4: skew across counter wrap
    dut_emits = 0;
    add_frame(2, 16'hFFFD, 0);
    for (int s = 0; s < N; s++)
      for (int k = 0; k < 5; k++) add_frame(s, 16'hFFFE + 16'(k), 0);
    play(8);
    chk("R4", 256'(dut_emits), 256'(5), "tuples across wrap");

    // R1: idle cycles between beats and between frames
    ptag = "R1"; dut_emits = 0;
    for (int k = 0; k < 3; k++) begin
      add_frame(0, CW'(300 + k), 3);
      add_frame_gappy(1, CW'(300 + k));
      add_frame(2, CW'(300 + k), 0);
    end
    play(8);
    chk("R1", 256'(dut_emits), 256'(3), "tuples with gaps");

    // R2: stray beats and an interrupted frame on stream 0
    ptag = "R2"; dut_emits = 0;
    add_stray(0, 3);
    add_partial(0, 5);
    for (int s = 0; s < N; s++)
      for (int k = 0; k < 3; k++) add_frame(s, CW'(400 + k), 0);
    play(8);
    chk("R2", 256'(dut_emits), 256'(3), "tuples after restart");

    // R6: starve stream 2 so streams 0 and 1 overflow
    ptag = "R6"; dut_emits = 0;
    for (int k = 0; k < 70; k++) begin
      add_frame(0, CW'(500 + k), 0);
      add_frame(1, CW'(500 + k), 0);
    end
    play(4);
    chk("R6", 256'(ovf_flag), 256'(3'b011), "flags after overflow");
    chk("R6", 256'(dut_emits), 256'(0), "no tuples while starved");

    // R7: periodic clears racing further overflows
    clr_period = 7;
    for (int k = 0; k < 10; k++) begin
      add_frame(0, CW'(600 + k), 0);
      add_frame(1, CW'(600 + k), 0);
    end
    play(4);
    clr_period = 0;
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    @(negedge clk);
    chk("R7", 256'(ovf_flag), 256'(0), "flags after clear");

    // R4: recover, stale frames on streams 0 and 1 get flushed
    ptag = "R4"; dut_emits = 0;
    add_frame(2, CW'(1000), 74);
    add_idle(0, 90); add_idle(1, 90);
    for (int s = 0; s < N; s++)
      for (int k = 0; k < 5; k++) add_frame(s, CW'(1001 + k), 0);
    play(8);
    chk("R4", 256'(dut_emits), 256'(5), "tuples after flush");
    chk("R5", 256'(lock), 256'(1), "lock after flush");

    summary();
    $finish;
  end

endmodule